// File: doc/BRIEF.md
# Two-Operator Envelope Sequencer

This block generates the loudness envelope for the two operators of one FM voice. It holds two identical envelope state machines. Slot 0 acts as the modulator and slot 1 acts as the carrier. Each slot has its own patch fields: attack rate, decay rate, sustain level, release rate and a hold bit. Both slots share one key-on pulse, one key-off pulse and a channel-level sustain override.

Each slot outputs a 7-bit attenuation, where 0 is loudest and 127 is silent, together with a phase code. A downstream operator adds the attenuation to its own output scaling.

The rate mapping is deliberately simple. On each clock, the active phase moves the attenuation by its 4-bit rate multiplied by the parameter `RATE_GAIN` (1 by default). The result saturates at the phase's limit. The phase changes on the clock after the limit has been reached.

Top module: `env_pair`

## Requirements
- R1: While reset is asserted, both slots show phase IDLE (code 0) and attenuation 127. Asserting reset forces this state at once, without waiting for a clock.
- R2: A key-on pulse puts a slot into ATTACK (code 1) on the next clock. On each following clock the attenuation falls by the attack rate and stops at 0. An attack rate of 0 leaves the attenuation where it is.
- R3: When a slot in ATTACK is already at 0, it moves to DECAY (code 2) on the next clock. In DECAY the attenuation rises by the decay rate and stops at sustain level × 8.
- R4: With its hold bit set, a slot that has reached the sustain target moves to SUSTAIN (code 3). It stays there until key-off.
- R5: With its hold bit clear, a slot that has reached the sustain target moves straight to RELEASE (code 4), without any key-off.
- R6: When a releasing slot sees key-off during ATTACK, DECAY or SUSTAIN, it moves to RELEASE with its attenuation unchanged on that clock. The attenuation then rises by the release rate and stops at 127. A releasing slot is the carrier, or the modulator with its hold bit clear.
- R7: While the channel sustain input is high, the release rate used is 5, whatever the patch release rate is.
- R8: The modulator with its hold bit set ignores key-off and continues through ATTACK, DECAY and SUSTAIN.
- R9: A release rate of 0 holds the attenuation constant in RELEASE.
- R10: A slot in RELEASE that is already at 127 moves to IDLE on the next clock.
- R11: Key-on in any phase, RELEASE included, restarts ATTACK from the current attenuation. The attenuation does not change on that clock.
- R12: Key-off while a slot is IDLE leaves its phase and its attenuation unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside the block |
| key_on | input | 1 | One-clock note start pulse |
| key_off | input | 1 | One-clock note end pulse |
| chan_sus | input | 1 | Channel sustain override; forces release rate 5 |
| mod_ar | input | 4 | Modulator attack rate |
| mod_dr | input | 4 | Modulator decay rate |
| mod_sl | input | 4 | Modulator sustain level (target = value × 8) |
| mod_rr | input | 4 | Modulator release rate |
| mod_hold | input | 1 | Modulator hold bit |
| car_ar | input | 4 | Carrier attack rate |
| car_dr | input | 4 | Carrier decay rate |
| car_sl | input | 4 | Carrier sustain level (target = value × 8) |
| car_rr | input | 4 | Carrier release rate |
| car_hold | input | 1 | Carrier hold bit |
| mod_level | output | 7 | Modulator attenuation, 0 loudest, 127 silent |
| mod_state | output | 3 | Modulator phase: 0 IDLE, 1 ATTACK, 2 DECAY, 3 SUSTAIN, 4 RELEASE |
| car_level | output | 7 | Carrier attenuation |
| car_state | output | 3 | Carrier phase code |

## Verification
A wrong phase shows up on the state port on the clock after the bad transition. The attenuation port then starts moving the wrong way, or stops moving, on the clock after that. The scenarios therefore sample mid-attack, mid-decay, in steady sustain and late in release.

Key-off races are sampled one or two clocks after the pulse. This exposes a level that jumps, a modulator that releases when it should hold, or a release rate that ignores the channel override. A missed hand-off from RELEASE to IDLE leaves the state code at 4 while the attenuation sits at 127. That is checked several clocks after silence is reached.

// File: rtl/env_pkg.sv
package env_pkg;

  localparam int RATE_W = 4;

  // release rate forced by the channel sustain override
  localparam logic [RATE_W-1:0] CHAN_SUS_RATE = 4'd5;

  typedef enum logic [2:0] {
    ENV_IDLE    = 3'd0,
    ENV_ATTACK  = 3'd1,
    ENV_DECAY   = 3'd2,
    ENV_SUSTAIN = 3'd3,
    ENV_RELEASE = 3'd4
  } env_state_e;

endpackage

// File: rtl/env_rate_sel.sv
module env_rate_sel
  import env_pkg::*;
#(
  parameter int LVL_W     = 7,
  parameter int RATE_GAIN = 1,
  localparam int STEP_W   = LVL_W + 1
) (
  input  env_state_e        phase,
  input  logic [RATE_W-1:0] ar,
  input  logic [RATE_W-1:0] dr,
  input  logic [RATE_W-1:0] sl,
  input  logic [RATE_W-1:0] rr,
  input  logic              chan_sus,
  output logic [STEP_W-1:0] step,
  output logic [LVL_W-1:0]  limit,
  output logic              up
);

  localparam int SL_SHIFT = LVL_W - RATE_W;
  localparam logic [31:0] STEP_MAX = 32'((1 << STEP_W) - 1);
  localparam logic [LVL_W-1:0] LVL_MAX = {LVL_W{1'b1}};

  logic [RATE_W-1:0] rate;
  logic [RATE_W-1:0] rel_rate;
  logic [LVL_W-1:0]  sus_target;
  logic [31:0]       prod;

  assign rel_rate   = chan_sus ? CHAN_SUS_RATE : rr;
  assign sus_target = {sl, {SL_SHIFT{1'b0}}};

  always_comb begin
    rate  = '0;
    limit = LVL_MAX;
    up    = 1'b1;
    unique case (phase)
      ENV_ATTACK: begin
        rate  = ar;
        limit = '0;
        up    = 1'b0;
      end
      ENV_DECAY: begin
        rate  = dr;
        limit = sus_target;
      end
      ENV_RELEASE: begin
        rate  = rel_rate;
      end
      default: begin
        rate  = '0;
      end
    endcase
  end

  assign prod = 32'(rate) * 32'(RATE_GAIN);
  assign step = (prod > STEP_MAX) ? STEP_MAX[STEP_W-1:0] : prod[STEP_W-1:0];

endmodule

// File: rtl/env_level_step.sv
module env_level_step #(
  parameter int LVL_W  = 7,
  parameter int STEP_W = LVL_W + 1
) (
  input  logic [LVL_W-1:0]  cur,
  input  logic [STEP_W-1:0] step,
  input  logic [LVL_W-1:0]  limit,
  input  logic              up,
  output logic [LVL_W-1:0]  nxt,
  output logic              reached
);

  localparam int EXT_W = STEP_W + 1;

  logic [EXT_W-1:0] cur_x;
  logic [EXT_W-1:0] step_x;
  logic [EXT_W-1:0] lim_x;
  logic [EXT_W-1:0] sum_x;
  logic [EXT_W-1:0] dif_x;

  always_comb begin
    cur_x  = EXT_W'(cur);
    step_x = EXT_W'(step);
    lim_x  = EXT_W'(limit);
    sum_x  = cur_x + step_x;
    dif_x  = cur_x - step_x;
    if (up) begin
      reached = (cur >= limit);
      nxt     = (sum_x >= lim_x) ? limit : sum_x[LVL_W-1:0];
    end else begin
      reached = (cur <= limit);
      nxt     = (cur_x >= lim_x + step_x) ? dif_x[LVL_W-1:0] : limit;
    end
  end

endmodule

// File: rtl/env_op.sv
module env_op
  import env_pkg::*;
#(
  parameter int LVL_W     = 7,
  parameter int RATE_GAIN = 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              is_mod,
  input  logic              key_on,
  input  logic              key_off,
  input  logic [RATE_W-1:0] ar,
  input  logic [RATE_W-1:0] dr,
  input  logic [RATE_W-1:0] sl,
  input  logic [RATE_W-1:0] rr,
  input  logic              hold,
  input  logic              chan_sus,
  output logic [LVL_W-1:0]  level,
  output logic [2:0]        state
);

  localparam int STEP_W = LVL_W + 1;
  localparam logic [LVL_W-1:0] LVL_MAX = {LVL_W{1'b1}};

  env_state_e        st_q, st_d;
  logic [LVL_W-1:0]  lvl_q, lvl_d;
  logic [STEP_W-1:0] step;
  logic [LVL_W-1:0]  limit;
  logic              up;
  logic [LVL_W-1:0]  lvl_nxt;
  logic              reached;
  logic              rel_ok;
  logic              active;

  env_rate_sel #(.LVL_W(LVL_W), .RATE_GAIN(RATE_GAIN)) u_rate (
    .phase    (st_q),
    .ar       (ar),
    .dr       (dr),
    .sl       (sl),
    .rr       (rr),
    .chan_sus (chan_sus),
    .step     (step),
    .limit    (limit),
    .up       (up)
  );

  env_level_step #(.LVL_W(LVL_W), .STEP_W(STEP_W)) u_step (
    .cur     (lvl_q),
    .step    (step),
    .limit   (limit),
    .up      (up),
    .nxt     (lvl_nxt),
    .reached (reached)
  );

  // a held modulator never enters release on key-off
  assign rel_ok = !(is_mod && hold);
  assign active = (st_q == ENV_ATTACK) || (st_q == ENV_DECAY) ||
                  (st_q == ENV_SUSTAIN);

  always_comb begin
    st_d  = st_q;
    lvl_d = lvl_q;
    if (key_on) begin
      st_d = ENV_ATTACK;
    end else if (key_off && rel_ok && active) begin
      st_d = ENV_RELEASE;
    end else begin
      unique case (st_q)
        ENV_ATTACK: begin
          if (reached) st_d = ENV_DECAY;
          else         lvl_d = lvl_nxt;
        end
        ENV_DECAY: begin
          if (reached) st_d = hold ? ENV_SUSTAIN : ENV_RELEASE;
          else         lvl_d = lvl_nxt;
        end
        ENV_RELEASE: begin
          if (reached) st_d = ENV_IDLE;
          else         lvl_d = lvl_nxt;
        end
        default: begin
          st_d  = st_q;
        end
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q  <= ENV_IDLE;
      lvl_q <= LVL_MAX;
    end else begin
      st_q  <= st_d;
      lvl_q <= lvl_d;
    end
  end

  assign level = lvl_q;
  assign state = st_q;

  // R10: IDLE is only ever seen at full attenuation
  p_idle_silent_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (st_q == ENV_IDLE) |-> (lvl_q == LVL_MAX));

  // R2: attack never raises the attenuation
  p_attack_falls_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (st_q == ENV_ATTACK && !key_on && !(key_off && rel_ok))
      |=> (lvl_q <= $past(lvl_q)));

  // R3: decay never lowers the attenuation
  p_decay_rises_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (st_q == ENV_DECAY && !key_on) |=> (lvl_q >= $past(lvl_q)));

  // R6: release never lowers the attenuation
  p_release_rises_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (st_q == ENV_RELEASE && !key_on) |=> (lvl_q >= $past(lvl_q)));

  // R11: key-on enters attack with no level jump
  p_keyon_attack_r11: assert property (@(posedge clk) disable iff (!rst_n)
    key_on |=> (st_q == ENV_ATTACK && lvl_q == $past(lvl_q)));

  // R8: a held modulator is never pushed into release
  p_mod_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (is_mod && hold && !key_on && st_q != ENV_RELEASE)
      |=> (st_q != ENV_RELEASE));

endmodule

// File: rtl/env_pair.sv
module env_pair
  import env_pkg::*;
#(
  parameter int LVL_W     = 7,
  parameter int RATE_GAIN = 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              key_on,
  input  logic              key_off,
  input  logic              chan_sus,
  input  logic [RATE_W-1:0] mod_ar,
  input  logic [RATE_W-1:0] mod_dr,
  input  logic [RATE_W-1:0] mod_sl,
  input  logic [RATE_W-1:0] mod_rr,
  input  logic              mod_hold,
  input  logic [RATE_W-1:0] car_ar,
  input  logic [RATE_W-1:0] car_dr,
  input  logic [RATE_W-1:0] car_sl,
  input  logic [RATE_W-1:0] car_rr,
  input  logic              car_hold,
  output logic [LVL_W-1:0]  mod_level,
  output logic [2:0]        mod_state,
  output logic [LVL_W-1:0]  car_level,
  output logic [2:0]        car_state
);

  localparam int NUM_OPS = 2;
  localparam int SYNC_W  = 2;

  logic [SYNC_W-1:0] rst_sync_q;
  logic              rst_core_n;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync_q <= '0;
    else        rst_sync_q <= {rst_sync_q[SYNC_W-2:0], 1'b1};
  end
  assign rst_core_n = rst_sync_q[SYNC_W-1];

  logic [NUM_OPS-1:0][RATE_W-1:0] ar_a, dr_a, sl_a, rr_a;
  logic [NUM_OPS-1:0]             hold_a;
  logic [NUM_OPS-1:0][LVL_W-1:0]  lvl_a;
  logic [NUM_OPS-1:0][2:0]        st_a;

  assign ar_a   = {car_ar, mod_ar};
  assign dr_a   = {car_dr, mod_dr};
  assign sl_a   = {car_sl, mod_sl};
  assign rr_a   = {car_rr, mod_rr};
  assign hold_a = {car_hold, mod_hold};

  for (genvar g = 0; g < NUM_OPS; g++) begin : g_op
    env_op #(.LVL_W(LVL_W), .RATE_GAIN(RATE_GAIN)) u_op (
      .clk      (clk),
      .rst_n    (rst_core_n),
      .is_mod   ((g == 0) ? 1'b1 : 1'b0),
      .key_on   (key_on),
      .key_off  (key_off),
      .ar       (ar_a[g]),
      .dr       (dr_a[g]),
      .sl       (sl_a[g]),
      .rr       (rr_a[g]),
      .hold     (hold_a[g]),
      .chan_sus (chan_sus),
      .level    (lvl_a[g]),
      .state    (st_a[g])
    );
  end

  assign mod_level = lvl_a[0];
  assign mod_state = st_a[0];
  assign car_level = lvl_a[1];
  assign car_state = st_a[1];

endmodule

// File: tb/tb_env_pair.sv
`timescale 1ns/1ps
module tb_env_pair;

  logic       clk = 1'b0;
  logic       rst_n;
  logic       key_on, key_off, chan_sus;
  logic [3:0] mod_ar, mod_dr, mod_sl, mod_rr, car_ar, car_dr, car_sl, car_rr;
  logic       mod_hold, car_hold;
  logic [6:0] mod_level, car_level;
  logic [2:0] mod_state, car_state;

  int n_chk  = 0;
  int n_fail = 0;

  always #2.5 clk = ~clk;

  env_pair dut (
    .clk(clk), .rst_n(rst_n), .key_on(key_on), .key_off(key_off),
    .chan_sus(chan_sus),
    .mod_ar(mod_ar), .mod_dr(mod_dr), .mod_sl(mod_sl), .mod_rr(mod_rr),
    .mod_hold(mod_hold),
    .car_ar(car_ar), .car_dr(car_dr), .car_sl(car_sl), .car_rr(car_rr),
    .car_hold(car_hold),
    .mod_level(mod_level), .mod_state(mod_state),
    .car_level(car_level), .car_state(car_state)
  );

  typedef struct packed {
    logic [31:0] tag;
    logic [3:0]  ar, dr, sl, rr;
    logic        mh, ch, cs;
    logic [7:0]  koff;   // edge index of key-off, 0 = none
    logic [7:0]  chk;    // edge index after which outputs are sampled
    logic [2:0]  ems;
    logic [6:0]  eml;
    logic [2:0]  ecs;
    logic [6:0]  ecl;
  } vec_t;

  localparam int NV = 12;
  localparam vec_t VEC [NV] = '{
    '{"R2  ", 4'd15, 4'd8,  4'd4, 4'd4,  1'b1, 1'b1, 1'b0, 8'd0,  8'd5,  3'd1, 7'd52,  3'd1, 7'd52},
    '{"R3  ", 4'd15, 4'd8,  4'd4, 4'd4,  1'b1, 1'b1, 1'b0, 8'd0,  8'd12, 3'd2, 7'd16,  3'd2, 7'd16},
    '{"R4  ", 4'd15, 4'd8,  4'd4, 4'd4,  1'b1, 1'b1, 1'b0, 8'd0,  8'd20, 3'd3, 7'd32,  3'd3, 7'd32},
    '{"R5  ", 4'd15, 4'd8,  4'd4, 4'd4,  1'b0, 1'b0, 1'b0, 8'd0,  8'd30, 3'd4, 7'd92,  3'd4, 7'd92},
    '{"R10 ", 4'd15, 4'd8,  4'd4, 4'd4,  1'b0, 1'b0, 1'b0, 8'd0,  8'd45, 3'd0, 7'd127, 3'd0, 7'd127},
    '{"R6  ", 4'd4,  4'd8,  4'd4, 4'd4,  1'b1, 1'b1, 1'b0, 8'd5,  8'd6,  3'd1, 7'd103, 3'd4, 7'd115},
    '{"R7  ", 4'd15, 4'd15, 4'd0, 4'd0,  1'b1, 1'b1, 1'b1, 8'd12, 8'd14, 3'd3, 7'd0,   3'd4, 7'd10},
    '{"R9  ", 4'd15, 4'd15, 4'd0, 4'd0,  1'b0, 1'b0, 1'b0, 8'd0,  8'd30, 3'd4, 7'd0,   3'd4, 7'd0},
    '{"R2  ", 4'd0,  4'd8,  4'd4, 4'd4,  1'b1, 1'b1, 1'b0, 8'd0,  8'd10, 3'd1, 7'd127, 3'd1, 7'd127},
    '{"R8  ", 4'd15, 4'd8,  4'd4, 4'd15, 1'b1, 1'b1, 1'b1, 8'd20, 8'd22, 3'd3, 7'd32,  3'd4, 7'd42},
    '{"R6  ", 4'd15, 4'd8,  4'd4, 4'd8,  1'b0, 1'b0, 1'b0, 8'd12, 8'd13, 3'd4, 7'd16,  3'd4, 7'd16},
    '{"R5  ", 4'd15, 4'd8,  4'd4, 4'd4,  1'b0, 1'b1, 1'b0, 8'd0,  8'd20, 3'd4, 7'd52,  3'd3, 7'd32}
  };

  task automatic check(input string what, input logic [2:0] as, input logic [6:0] al,
                       input logic [2:0] es, input logic [6:0] el);
    n_chk++;
    if (as !== es || al !== el) begin
      n_fail++;
      $display("FAIL %s: state/level actual %0d/%0d expected %0d/%0d", what, as, al, es, el);
    end
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst_n = 1'b0; key_on = 1'b0; key_off = 1'b0;
    repeat (2) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
  endtask

  task automatic run(input vec_t v);
    do_reset();
    mod_ar = v.ar; mod_dr = v.dr; mod_sl = v.sl; mod_rr = v.rr; mod_hold = v.mh;
    car_ar = v.ar; car_dr = v.dr; car_sl = v.sl; car_rr = v.rr; car_hold = v.ch;
    chan_sus = v.cs;
    key_on = 1'b1;
    @(posedge clk);
    @(negedge clk);
    key_on = 1'b0;
    for (int e = 1; e <= int'(v.chk); e++) begin
      key_off = (e == int'(v.koff));
      @(posedge clk);
      @(negedge clk);
    end
    key_off = 1'b0;
    check({string'(v.tag), " modulator"}, mod_state, mod_level, v.ems, v.eml);
    check({string'(v.tag), " carrier"},   car_state, car_level, v.ecs, v.ecl);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_fail);
    $finish;
  end

  initial begin
    rst_n = 1'b0; key_on = 1'b0; key_off = 1'b0; chan_sus = 1'b0;
    mod_ar = '0; mod_dr = '0; mod_sl = '0; mod_rr = '0; mod_hold = 1'b0;
    car_ar = '0; car_dr = '0; car_sl = '0; car_rr = '0; car_hold = 1'b0;
    repeat (3) @(negedge clk);
    // R1: reset state
    check("R1 modulator", mod_state, mod_level, 3'd0, 7'd127);
    check("R1 carrier",   car_state, car_level, 3'd0, 7'd127);

    for (int i = 0; i < NV; i++) run(VEC[i]);

    // R12: key-off while idle changes nothing
    do_reset();
    key_off = 1'b1;
    @(posedge clk);
    @(negedge clk);
    key_off = 1'b0;
    @(posedge clk);
    @(negedge clk);
    check("R12 modulator", mod_state, mod_level, 3'd0, 7'd127);
    check("R12 carrier",   car_state, car_level, 3'd0, 7'd127);

    // R11: retrigger from release at level 92
    run(VEC[3]);
    key_on = 1'b1;
    @(posedge clk);
    @(negedge clk);
    key_on = 1'b0;
    check("R11 carrier hold level", car_state, car_level, 3'd1, 7'd92);
    @(posedge clk);
    @(negedge clk);
    check("R11 modulator attack step", mod_state, mod_level, 3'd1, 7'd77);

    // R1: asynchronous reset in mid-attack
    rst_n = 1'b0;
    #1;
    check("R1 async modulator", mod_state, mod_level, 3'd0, 7'd127);
    check("R1 async carrier",   car_state, car_level, 3'd0, 7'd127);
    rst_n = 1'b1;

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_fail);
    $finish;
  end

endmodule